// File: doc/BRIEF.md
# Multi-Channel Compare Match Timer

This block is a register-mapped timer with a configurable number of independent channels. Each channel has an up-counter, a compare register and a 16-bit control/status word. A single shared start register holds one run bit per channel. When a running channel's counter equals its compare value, the channel raises a sticky match flag. In periodic mode the channel also returns its counter to zero, so each period lasts compare+1 count ticks. A counter that wraps from all ones to zero without a match sets a separate overflow flag. Each channel drives an interrupt request when its match flag is set and interrupt requests are selected in its control word.

All channels share one free-running divider. Each channel chooses the divider output it counts through a clock-select field. Software clears flags with a read-modify-write that writes zero to the flag bits. A write to a counter is not applied at once: the new value appears on the second count tick of that channel after the write, and reads return the old value until then. The register bus is a simple synchronous interface. A write takes effect on the clock edge where enable and write are both high. Read data is combinational from the address.

Top module: `match_timer`

## Requirements
- R1: After reset the start register reads 0, every control word and counter reads 0, every compare register reads all ones, and every interrupt output is low.
- R2: The start register is at byte address 0x00. Channel n's block starts at 0x10 + 0x10*n, with the control word at +0x0, the counter at +0x4 and the compare register at +0x8. Any other address reads 0. The writable control bits are bit 8, bit 7, bits 5:4 and bits 2:0; every other non-flag bit reads 0.
- R3: Bit n of the start register runs channel n while it is 1. A stopped channel holds its counter value.
- R4: With control bit 8 set, a running counter that equals the compare value goes to 0 on the next count tick, and that same tick sets the match flag (bit 15). A period is therefore compare+1 ticks.
- R5: With control bit 8 clear, a match sets the match flag and the counter keeps counting upward.
- R6: When a running counter rolls from all ones to 0 and the compare value is not all ones, the overflow flag (bit 14) is set.
- R7: A control write with 0 in a flag bit clears that flag, and a 1 leaves it unchanged. A flag set by hardware in the same cycle as a clearing write stays set.
- R8: Interrupt output n is high exactly when channel n's match flag is set and its bits 5:4 equal 2.
- R9: Control bits 2:0 select the count tick: 7 counts every clock, 4 every 8 clocks, 5 every 32 clocks and 6 every 128 clocks. Values 0 to 3 give no ticks.
- R10: A counter write is applied on the channel's second count tick after the write cycle. Until then, reads return the previous counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, also the reference for the divider |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational from the address |
| irq_o | output | NCH | Per-channel interrupt request |

## Verification
A wrong count or wrap state shows as a wrong counter read on the very next count tick. The bench therefore samples the counter at every clock edge through whole periodic cycles and across a rollover. A stuck or lost flag shows at the interrupt pin, or in the control word read, on the cycle after the tick that should have set it. A divider or select fault only shows as a rate error, so it is measured over whole divider periods. A fault in the counter-write delay shows within two ticks as a value that appears one tick early or late.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  localparam int unsigned CSR_W    = 16;
  localparam int unsigned BIT_MF   = 15;
  localparam int unsigned BIT_OF   = 14;
  localparam int unsigned NDIV     = 3;            // divided rates /8 /32 /128
  localparam int unsigned TICK_N   = NDIV + 1;     // plus undivided
  localparam int unsigned DIV_W    = 1 + 2 * NDIV; // widest divider stage
  localparam logic [1:0]  REQ_IRQ  = 2'd2;

  typedef struct packed {
    logic       periodic;
    logic       out_ie;
    logic [1:0] req;
    logic [2:0] clk_sel;
  } chan_cfg_t;
endpackage

// File: rtl/match_timer_prescaler.sv
module match_timer_prescaler
  import match_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [TICK_N-1:0] tick_o
);
  logic [DIV_W-1:0] div_q, div_d;

  always_comb div_d = div_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  // stage i divides by 2^(3+2i); the last slot is the undivided clock
  for (genvar i = 0; i < NDIV; i++) begin : g_stage
    localparam int unsigned SH = 3 + 2 * i;
    assign tick_o[i] = &div_q[SH-1:0];
  end
  assign tick_o[TICK_N-1] = 1'b1;

  assert_div_spacing_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o[0] |=> !tick_o[0]);
  assert_div_nesting_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o[NDIV-1] |-> tick_o[0]);
endmodule

// File: rtl/match_timer_channel.sv
module match_timer_channel
  import match_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [TICK_N-1:0] tick_i,
  input  logic              wr_csr_i,
  input  logic              wr_cnt_i,
  input  logic              wr_cmp_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CSR_W-1:0]  csr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              irq_o
);
  chan_cfg_t        cfg_q, cfg_d;
  logic             mf_q, mf_d, of_q, of_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cmp_q, cmp_d, pend_val_q, pend_val_d;
  logic             pend_q, pend_d, pend_ph_q, pend_ph_d;
  logic             tick, load_now, step, equal, hit, roll;

  always_comb begin
    tick     = cfg_q.clk_sel[2] & tick_i[cfg_q.clk_sel[1:0]];
    load_now = pend_q & pend_ph_q & tick;
    step     = run_i & tick & ~load_now;
    equal    = (cnt_q == cmp_q);
    hit      = step & equal;
    roll     = step & (&cnt_q) & ~equal;

    cnt_d = cnt_q;
    if (load_now)  cnt_d = pend_val_q;
    else if (step) cnt_d = (hit && cfg_q.periodic) ? '0 : cnt_q + 1'b1;

    pend_d     = pend_q;
    pend_ph_d  = pend_ph_q;
    pend_val_d = pend_val_q;
    if (wr_cnt_i) begin
      pend_d     = 1'b1;
      pend_ph_d  = 1'b0;
      pend_val_d = wdata_i;
    end else if (pend_q && tick) begin
      if (pend_ph_q) pend_d = 1'b0;
      pend_ph_d = 1'b1;
    end

    cmp_d = wr_cmp_i ? wdata_i : cmp_q;
    cfg_d = cfg_q;
    if (wr_csr_i) cfg_d = '{periodic: wdata_i[8], out_ie: wdata_i[7],
                            req: wdata_i[5:4], clk_sel: wdata_i[2:0]};
    mf_d = hit  | (mf_q & ~(wr_csr_i & ~wdata_i[BIT_MF]));
    of_d = roll | (of_q & ~(wr_csr_i & ~wdata_i[BIT_OF]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      mf_q       <= 1'b0;
      of_q       <= 1'b0;
      cnt_q      <= '0;
      cmp_q      <= '1;
      pend_q     <= 1'b0;
      pend_ph_q  <= 1'b0;
      pend_val_q <= '0;
    end else begin
      cfg_q      <= cfg_d;
      mf_q       <= mf_d;
      of_q       <= of_d;
      cnt_q      <= cnt_d;
      cmp_q      <= cmp_d;
      pend_q     <= pend_d;
      pend_ph_q  <= pend_ph_d;
      pend_val_q <= pend_val_d;
    end
  end

  assign csr_o = {mf_q, of_q, 5'b0, cfg_q.periodic, cfg_q.out_ie, 1'b0,
                  cfg_q.req, 1'b0, cfg_q.clk_sel};
  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;
  assign irq_o = mf_q & (cfg_q.req == REQ_IRQ);

  assert_hold_when_stopped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_now) |=> $stable(cnt_q));
  assert_periodic_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick && !load_now && cfg_q.periodic && cnt_q == cmp_q) |=> (cnt_q == '0 && mf_q));
  assert_rollover_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick && !load_now && (&cnt_q) && cnt_q != cmp_q) |=> of_q);
  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mf_q && !(wr_csr_i && !wdata_i[BIT_MF])) |=> mf_q);
endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [NCH-1:0]    irq_o
);
  localparam int unsigned BLK_LSB = 4;
  localparam int unsigned BLK_W   = ADDR_W - BLK_LSB;

  logic [BLK_W-1:0]  blk;
  logic [1:0]        word;
  logic              wr, wr_start;
  logic [NCH-1:0]    run_q, run_d;
  logic [TICK_N-1:0] ticks;
  logic [CSR_W-1:0]  csr_w [NCH];
  logic [CNT_W-1:0]  cnt_w [NCH];
  logic [CNT_W-1:0]  cmp_w [NCH];
  logic              unused_addr;

  assign blk         = bus_addr_i[ADDR_W-1:BLK_LSB];
  assign word        = bus_addr_i[3:2];
  assign unused_addr = ^bus_addr_i[1:0];
  assign wr          = bus_en_i & bus_we_i;
  assign wr_start    = wr & (blk == '0) & (word == 2'd0);

  always_comb run_d = wr_start ? bus_wdata_i[NCH-1:0] : run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_d;
  end

  match_timer_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (ticks)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic sel;
    assign sel = wr & (blk == BLK_W'(n + 1));
    match_timer_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_q[n]),
      .tick_i   (ticks),
      .wr_csr_i (sel & (word == 2'd0)),
      .wr_cnt_i (sel & (word == 2'd1)),
      .wr_cmp_i (sel & (word == 2'd2)),
      .wdata_i  (bus_wdata_i[CNT_W-1:0]),
      .csr_o    (csr_w[n]),
      .cnt_o    (cnt_w[n]),
      .cmp_o    (cmp_w[n]),
      .irq_o    (irq_o[n])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (blk == '0 && word == 2'd0) bus_rdata_o = DATA_W'(run_q);
    for (int n = 0; n < NCH; n++) begin
      if (blk == BLK_W'(n + 1)) begin
        case (word)
          2'd0:    bus_rdata_o = DATA_W'(csr_w[n]);
          2'd1:    bus_rdata_o = DATA_W'(cnt_w[n]);
          2'd2:    bus_rdata_o = DATA_W'(cmp_w[n]);
          default: bus_rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: tb/tb_match_timer.sv
`timescale 1ns/1ps
module tb_match_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en, we;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic [1:0]  irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  match_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(en), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // {req tag, write, address, data, expected read}
  localparam int NV = 15;
  localparam logic [76:0] VEC [NV] = '{
    {4'd1, 1'b0, 8'h00, 32'h0,        32'h0},
    {4'd1, 1'b0, 8'h10, 32'h0,        32'h0},
    {4'd1, 1'b0, 8'h14, 32'h0,        32'h0},
    {4'd1, 1'b0, 8'h18, 32'h0,        32'hFFFF_FFFF},
    {4'd1, 1'b0, 8'h28, 32'h0,        32'hFFFF_FFFF},
    {4'd2, 1'b0, 8'h0C, 32'h0,        32'h0},
    {4'd2, 1'b1, 8'h10, 32'h0000_FFFF, 32'h0},
    {4'd2, 1'b0, 8'h10, 32'h0,        32'h0000_01B7},
    {4'd2, 1'b1, 8'h18, 32'h4,        32'h0},
    {4'd2, 1'b0, 8'h18, 32'h0,        32'h4},
    {4'd2, 1'b1, 8'h28, 32'h1234,     32'h0},
    {4'd2, 1'b0, 8'h28, 32'h0,        32'h1234},
    {4'd2, 1'b0, 8'h18, 32'h0,        32'h4},
    {4'd2, 1'b1, 8'h10, 32'h0000_0127, 32'h0},
    {4'd2, 1'b0, 8'h10, 32'h0,        32'h0000_0127}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    en = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 en = 1'b0; we = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    peek(a, d);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v, v2, a0;
    en = 0; we = 0; addr = 0; wdata = 0; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 irq at reset", {30'b0, irq}, 32'h0);

    // register table: reset values (R1), map and writable bits (R2)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][71:64], v);
        chk($sformatf("R%0d table entry %0d", VEC[i][76:73], i), v, VEC[i][31:0]);
      end
    end

    // R4 periodic count with compare 4, R8 interrupt, R3 start bit
    wr(8'h00, 32'h1);
    for (int i = 0; i < 12; i++) begin
      rd(8'h14, v);
      chk("R4 periodic counter", v, 32'(i % 5));
      chk("R8 irq after match", {31'b0, irq[0]}, {31'b0, (i >= 5)});
    end
    wr(8'h00, 32'h0);
    rd(8'h14, v);
    repeat (5) @(negedge clk);
    rd(8'h14, v2);
    chk("R3 stopped counter holds", v2, v);

    // R7 flag write semantics
    rd(8'h10, v);
    chk("R4 match flag set", v, 32'h8127);
    wr(8'h10, 32'h8127);
    rd(8'h10, v);
    chk("R7 write 1 keeps flag", v, 32'h8127);
    chk("R7 irq kept", {31'b0, irq[0]}, 32'h1);
    wr(8'h10, 32'h0127);
    rd(8'h10, v);
    chk("R7 write 0 clears flag", v, 32'h0127);
    chk("R8 irq cleared", {31'b0, irq[0]}, 32'h0);

    // R8 match flag with request type 1 gives no interrupt
    wr(8'h10, 32'h0117);
    wr(8'h00, 32'h1);
    repeat (8) @(negedge clk);
    wr(8'h00, 32'h0);
    rd(8'h10, v);
    chk("R8 flag set in request mode 1", v, 32'h8117);
    chk("R8 no irq in request mode 1", {31'b0, irq[0]}, 32'h0);
    wr(8'h10, 32'h8127);
    rd(8'h10, v);
    chk("R8 irq with request mode 2", {31'b0, irq[0]}, 32'h1);

    // R10 counter write lands on the second tick
    rd(8'h14, a0);
    wr(8'h14, 32'd100);
    rd(8'h14, v);
    chk("R10 old value after write", v, a0);
    rd(8'h14, v);
    chk("R10 old value after one tick", v, a0);
    rd(8'h14, v);
    chk("R10 new value after two ticks", v, 32'd100);

    // R5 free-running match and R6 rollover on channel 1
    wr(8'h20, 32'h0027);
    wr(8'h28, 32'h5);
    wr(8'h24, 32'hFFFF_FFFE);
    repeat (3) @(negedge clk);
    wr(8'h00, 32'h2);
    for (int i = 0; i < 9; i++) begin
      rd(8'h24, v);
      chk("R6 counter across rollover", v, 32'hFFFF_FFFE + 32'(i));
      if (i == 2) begin
        peek(8'h20, v);
        chk("R6 overflow flag only", v, 32'h4027);
      end
      if (i == 8) begin
        peek(8'h20, v);
        chk("R5 match flag, counting on", v, 32'hC027);
        chk("R8 channel 1 irq", {31'b0, irq[1]}, 32'h1);
      end
    end

    // R9 clock select rates, channel 1 running free
    wr(8'h20, 32'h0024);
    rd(8'h24, v);
    repeat (63) @(negedge clk);
    rd(8'h24, v2);
    chk("R9 divide by 8", v2 - v, 32'd8);
    wr(8'h20, 32'h0025);
    rd(8'h24, v);
    repeat (63) @(negedge clk);
    rd(8'h24, v2);
    chk("R9 divide by 32", v2 - v, 32'd2);
    wr(8'h20, 32'h0026);
    rd(8'h24, v);
    repeat (127) @(negedge clk);
    rd(8'h24, v2);
    chk("R9 divide by 128", v2 - v, 32'd1);
    wr(8'h20, 32'h0020);
    rd(8'h24, v);
    repeat (63) @(negedge clk);
    rd(8'h24, v2);
    chk("R9 invalid select, no ticks", v2 - v, 32'd0);
    rd(8'h00, v);
    chk("R3 start register readback", v, 32'h2);

    done = 1;
    finish_run();
  end
endmodule